// File: doc/BRIEF.md
# Switching Bilateral Denoise Filter

This block removes mixed noise from an 8-bit grayscale stream, one pixel per cycle. Each cycle an external line-buffer stage may present a complete 5x5 neighbourhood together with a position tag. The block first decides what kind of noise, if any, affects the centre pixel. It then filters that pixel with a bilateral kernel, and the behaviour of the range term follows the decision.

The decision works on the four corner 3x3 sub-windows of the neighbourhood, each of which contains the centre pixel. Their medians are ranked, and the spread of that ranked set shows whether an edge or texture crosses the window. When the spread is large, the median nearest to the centre is taken as reference. When it is small, the average of the two middle ranks is used. The distance between the centre and the reference gives one of three labels. A clean pixel is passed through unchanged. A Gaussian-noisy pixel gets a conventional bilateral average. An impulse-noisy pixel gets a bilateral average whose range term is measured against the reference, and the pixel's own contribution is removed. The result and its label come out a fixed number of cycles after the input, carrying the same tag.

Top module: `sbf_top`

## Requirements
- R1: Each quadrant median is the 5th smallest of the nine pixels of its 3x3 corner sub-window. Q0 is rows 0-2 / columns 0-2, Q1 is rows 0-2 / columns 2-4, Q2 is rows 2-4 / columns 0-2 and Q3 is rows 2-4 / columns 2-4. Window pixel (row r, column c) sits at bits [(5r+c)*8 +: 8] of `in_win`, and the centre is pixel 12.
- R2: If the largest quadrant median minus the smallest is strictly greater than `thr_edge`, the reference is the quadrant median with the smallest absolute distance to the centre. Ties go to the lowest quadrant index.
- R3: Otherwise the reference is floor((m1+m2)/2), where m0<=m1<=m2<=m3 are the ranked quadrant medians.
- R4: With d = |centre - reference|, the class is 2'b10 (impulse) when d >= `thr_imp`, 2'b01 (Gaussian) when `thr_gauss` <= d < `thr_imp`, and 2'b00 (clean) otherwise. The code 2'b11 never appears.
- R5: A clean pixel is output equal to the input centre pixel.
- R6: Gaussian mode uses base = centre and gives each pixel p the weight w = s(p)*g(|p - base|). The spatial factor s is 4, 2 or 1 for Chebyshev distance 0, 1 or 2 from the centre. The range factor g(x) is 16 - floor(x/4) when floor(x/4) < 16, and 0 otherwise. The output is floor(sum(w*p) / sum(w)).
- R7: Impulse mode uses the same weights with base = reference, and the centre's weight is zero. If all weights are zero, the output is the reference.
- R8: `out_valid` is high exactly 11 cycles after each accepted `in_valid` cycle and at no other time. A new window can be accepted every cycle, and `out_tag` returns the tag of that window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Window present this cycle |
| in_win | input | 200 | 25 pixels, row-major, 8 bits each |
| in_tag | input | 16 | Frame position tag |
| thr_edge | input | 8 | Spread above which the window counts as edged |
| thr_imp | input | 8 | Impulse distance threshold |
| thr_gauss | input | 8 | Gaussian distance threshold |
| out_valid | output | 1 | Result present |
| out_pix | output | 8 | Filtered pixel |
| out_class | output | 2 | Noise class of the pixel |
| out_tag | output | 16 | Tag of the result |

## Verification
The assertions assume that `thr_imp` is larger than `thr_gauss`. They also assume that the three thresholds stay fixed while any window is in flight, because the classifier samples them in its own stage. The stimulus changes thresholds only after the pipeline has drained, and it always keeps the impulse threshold above the Gaussian one. The divider bound checks rely on every numerator being a weighted average of 8-bit values, which holds for any window.

// File: rtl/sbf_pkg.sv
package sbf_pkg;
  localparam int WIN  = 5;
  localparam int NPIX = WIN * WIN;
  localparam int CTR  = NPIX / 2;

  typedef enum logic [1:0] {
    CLS_CLEAN = 2'b00,
    CLS_GAUSS = 2'b01,
    CLS_IMP   = 2'b10
  } sbf_cls_e;

  // window index of tap k (row-major, 0..8) of corner quadrant q
  function automatic int quad_tap(input int q, input int k);
    return ((q / 2) * 2 + k / 3) * WIN + (q % 2) * 2 + k % 3;
  endfunction

  // spatial factor: 4 at the centre, 2 on the inner ring, 1 on the outer ring
  function automatic int unsigned spatial_wt(input int p);
    int dr, dc, ch;
    dr = (p / WIN) - 2;
    dc = (p % WIN) - 2;
    if (dr < 0) dr = -dr;
    if (dc < 0) dc = -dc;
    ch = (dr > dc) ? dr : dc;
    return (ch == 0) ? 4 : (ch == 1) ? 2 : 1;
  endfunction
endpackage

// File: rtl/sbf_qmed.sv
module sbf_qmed #(
  parameter int PW = 8
) (
  input  logic [9*PW-1:0] taps,
  output logic [PW-1:0]   med
);
  logic [PW-1:0] arr [9];
  logic [PW-1:0] tmp;

  // odd-even transposition network, nine passes
  always_comb begin
    for (int i = 0; i < 9; i++) arr[i] = taps[i*PW +: PW];
    tmp = '0;
    for (int pass = 0; pass < 9; pass++) begin
      for (int i = pass % 2; i + 1 < 9; i += 2) begin
        if (arr[i] > arr[i+1]) begin
          tmp      = arr[i];
          arr[i]   = arr[i+1];
          arr[i+1] = tmp;
        end
      end
    end
    med = arr[4];
  end
endmodule

// File: rtl/sbf_div_stage.sv
module sbf_div_stage #(
  parameter int NUM_W = 20,
  parameter int DEN_W = 12,
  parameter int QW    = 8,
  parameter int SH    = 7,
  parameter int PAY_W = 34
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vi,
  input  logic [NUM_W-1:0] rem_i,
  input  logic [DEN_W-1:0] den_i,
  input  logic [QW-1:0]    q_i,
  input  logic [PAY_W-1:0] pay_i,
  output logic             vo,
  output logic [NUM_W-1:0] rem_o,
  output logic [DEN_W-1:0] den_o,
  output logic [QW-1:0]    q_o,
  output logic [PAY_W-1:0] pay_o
);
  logic [NUM_W-1:0] trial, rem_n;
  logic [QW-1:0]    q_n;
  logic             take;

  always_comb begin
    trial = NUM_W'(den_i) << SH;
    take  = (rem_i >= trial);
    rem_n = take ? rem_i - trial : rem_i;
    q_n   = q_i;
    q_n[SH] = take;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vo <= 1'b0;
    else        vo <= vi;
  end

  always_ff @(posedge clk) begin
    if (vi) begin
      rem_o <= rem_n;
      den_o <= den_i;
      q_o   <= q_n;
      pay_o <= pay_i;
    end
  end

  // R8: one register of delay per stage
  p_valid_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    vo == $past(vi));
  // R6/R7: restoring step leaves the remainder below the shifted divisor
  p_rem_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (vo && den_o != '0) |-> (rem_o < (NUM_W'(den_o) << SH)));
endmodule

// File: rtl/sbf_top.sv
module sbf_top #(
  parameter int PW      = 8,
  parameter int TAG_W   = 16,
  parameter int R_MAX   = 16,
  parameter int R_SHIFT = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  input  logic [sbf_pkg::NPIX*PW-1:0] in_win,
  input  logic [TAG_W-1:0]            in_tag,
  input  logic [PW-1:0]               thr_edge,
  input  logic [PW-1:0]               thr_imp,
  input  logic [PW-1:0]               thr_gauss,
  output logic                        out_valid,
  output logic [PW-1:0]               out_pix,
  output logic [1:0]                  out_class,
  output logic [TAG_W-1:0]            out_tag
);
  import sbf_pkg::*;

  localparam int WW    = $clog2(4 * R_MAX + 1);
  localparam int DEN_W = WW + $clog2(NPIX);
  localparam int NUM_W = DEN_W + PW;
  localparam int QW    = PW;
  localparam int PAY_W = 2 + 2 * PW + TAG_W;
  localparam int WBITS = NPIX * PW;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rs_q;
  logic       rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  function automatic logic [WW-1:0] rng(input logic [PW-1:0] d);
    logic [PW-1:0] sh;
    sh = d >> R_SHIFT;
    if (sh >= PW'(R_MAX)) return '0;
    return WW'(R_MAX - int'(sh));
  endfunction

  // ---------------- stage 1: quadrant medians
  logic [9*PW-1:0] q_taps [4];
  logic [PW-1:0]   q_med  [4];
  for (genvar q = 0; q < 4; q++) begin : g_quad
    for (genvar k = 0; k < 9; k++) begin : g_tap
      assign q_taps[q][k*PW +: PW] = in_win[quad_tap(q, k)*PW +: PW];
    end
    sbf_qmed #(.PW(PW)) i_qmed (.taps(q_taps[q]), .med(q_med[q]));
  end

  logic             s1_v;
  logic [WBITS-1:0] s1_win;
  logic [TAG_W-1:0] s1_tag;
  logic [PW-1:0]    s1_med [4];

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) s1_v <= 1'b0;
    else        s1_v <= in_valid;
  end
  always_ff @(posedge clk) begin
    if (in_valid) begin
      s1_win <= in_win;
      s1_tag <= in_tag;
      for (int q = 0; q < 4; q++) s1_med[q] <= q_med[q];
    end
  end

  // ---------------- stage 2: reference selection and classification
  logic [PW-1:0] sm [4];
  logic [PW-1:0] ctr1, close_v, best_d, dq, ref_n, dif_n, t4;
  logic [PW:0]   msum;
  sbf_cls_e      cls_n;

  always_comb begin
    for (int i = 0; i < 4; i++) sm[i] = s1_med[i];
    t4 = '0;
    for (int pass = 0; pass < 3; pass++) begin
      for (int i = 0; i < 3; i++) begin
        if (sm[i] > sm[i+1]) begin
          t4 = sm[i]; sm[i] = sm[i+1]; sm[i+1] = t4;
        end
      end
    end
    ctr1    = s1_win[CTR*PW +: PW];
    close_v = s1_med[0];
    best_d  = (s1_med[0] > ctr1) ? s1_med[0] - ctr1 : ctr1 - s1_med[0];
    for (int q = 1; q < 4; q++) begin
      dq = (s1_med[q] > ctr1) ? s1_med[q] - ctr1 : ctr1 - s1_med[q];
      if (dq < best_d) begin
        best_d  = dq;
        close_v = s1_med[q];
      end
    end
    msum  = {1'b0, sm[1]} + {1'b0, sm[2]};
    ref_n = ((sm[3] - sm[0]) > thr_edge) ? close_v : msum[PW:1];
    dif_n = (ctr1 > ref_n) ? ctr1 - ref_n : ref_n - ctr1;
    if (dif_n >= thr_imp)        cls_n = CLS_IMP;
    else if (dif_n >= thr_gauss) cls_n = CLS_GAUSS;
    else                         cls_n = CLS_CLEAN;
  end

  logic             s2_v;
  logic [WBITS-1:0] s2_win;
  logic [TAG_W-1:0] s2_tag;
  logic [PW-1:0]    s2_ref;
  sbf_cls_e         s2_cls;

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) s2_v <= 1'b0;
    else        s2_v <= s1_v;
  end
  always_ff @(posedge clk) begin
    if (s1_v) begin
      s2_win <= s1_win;
      s2_tag <= s1_tag;
      s2_ref <= ref_n;
      s2_cls <= cls_n;
    end
  end

  // ---------------- stage 3: switched range kernel, weighted sums
  logic [PW-1:0]    base, pix, dd;
  logic [WW-1:0]    w;
  logic [NUM_W-1:0] num_n;
  logic [DEN_W-1:0] den_n;

  always_comb begin
    base  = (s2_cls == CLS_IMP) ? s2_ref : s2_win[CTR*PW +: PW];
    num_n = '0;
    den_n = '0;
    for (int p = 0; p < NPIX; p++) begin
      pix = s2_win[p*PW +: PW];
      dd  = (pix > base) ? pix - base : base - pix;
      w   = WW'(spatial_wt(p) * rng(dd));
      if (s2_cls == CLS_IMP && p == CTR) w = '0;
      num_n = num_n + NUM_W'(w) * NUM_W'(pix);
      den_n = den_n + DEN_W'(w);
    end
  end

  logic             dv_v   [QW+1];
  logic [NUM_W-1:0] dv_rem [QW+1];
  logic [DEN_W-1:0] dv_den [QW+1];
  logic [QW-1:0]    dv_q   [QW+1];
  logic [PAY_W-1:0] dv_pay [QW+1];

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) dv_v[0] <= 1'b0;
    else        dv_v[0] <= s2_v;
  end
  always_ff @(posedge clk) begin
    if (s2_v) begin
      dv_rem[0] <= num_n;
      dv_den[0] <= den_n;
      dv_q[0]   <= '0;
      dv_pay[0] <= {s2_cls, s2_win[CTR*PW +: PW], s2_ref, s2_tag};
    end
  end

  // ---------------- stages 4..: one quotient bit per stage, MSB first
  for (genvar k = 0; k < QW; k++) begin : g_div
    sbf_div_stage #(
      .NUM_W(NUM_W), .DEN_W(DEN_W), .QW(QW), .SH(QW-1-k), .PAY_W(PAY_W)
    ) i_stage (
      .clk(clk), .rst_n(rst_i),
      .vi(dv_v[k]), .rem_i(dv_rem[k]), .den_i(dv_den[k]), .q_i(dv_q[k]), .pay_i(dv_pay[k]),
      .vo(dv_v[k+1]), .rem_o(dv_rem[k+1]), .den_o(dv_den[k+1]), .q_o(dv_q[k+1]),
      .pay_o(dv_pay[k+1])
    );
  end

  logic [1:0]    o_cls;
  logic [PW-1:0] o_ctr, o_ref;
  assign {o_cls, o_ctr, o_ref, out_tag} = dv_pay[QW];
  assign out_valid = dv_v[QW];
  assign out_class = o_cls;
  assign out_pix   = (o_cls == CLS_CLEAN) ? o_ctr :
                     (dv_den[QW] == '0)   ? o_ref : dv_q[QW];

  // ---------------- assertions
  logic rank_ok;
  logic [PW-1:0] tp;
  int lt, gt;
  always_comb begin
    rank_ok = 1'b1;
    for (int q = 0; q < 4; q++) begin
      lt = 0; gt = 0;
      for (int k = 0; k < 9; k++) begin
        tp = s1_win[quad_tap(q, k)*PW +: PW];
        if (tp < s1_med[q]) lt++;
        if (tp > s1_med[q]) gt++;
      end
      if (lt > 4 || gt > 4) rank_ok = 1'b0;
    end
  end

  p_median_rank_r1: assert property (@(posedge clk) disable iff (!rst_i)
    s1_v |-> rank_ok);
  p_ref_in_span_r2: assert property (@(posedge clk) disable iff (!rst_i)
    s1_v |=> (s2_ref >= $past(sm[0]) && s2_ref <= $past(sm[3])));
  p_class_legal_r4: assert property (@(posedge clk) disable iff (!rst_i)
    out_valid |-> out_class != 2'b11);
  p_gauss_den_r6: assert property (@(posedge clk) disable iff (!rst_i)
    (dv_v[0] && dv_pay[0][PAY_W-1 -: 2] == CLS_GAUSS) |-> dv_den[0] >= DEN_W'(4 * R_MAX));
endmodule

// File: tb/test_sbf_top.sv
module test_sbf_top;
  localparam int LAT = 11;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic [199:0] in_win;
  logic [15:0]  in_tag;
  logic [7:0]   thr_edge, thr_imp, thr_gauss;
  logic         out_valid;
  logic [7:0]   out_pix;
  logic [1:0]   out_class;
  logic [15:0]  out_tag;

  always #2 clk = ~clk;

  sbf_top i_sbf_top (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_win(in_win), .in_tag(in_tag),
    .thr_edge(thr_edge), .thr_imp(thr_imp), .thr_gauss(thr_gauss),
    .out_valid(out_valid), .out_pix(out_pix), .out_class(out_class), .out_tag(out_tag)
  );

  typedef struct { int pix; int cls; int tag; int due; string req; } item_t;
  item_t sb[$];
  int total = 0, bad = 0, cyc = 0, tagc = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int iabs(input int a);
    return (a < 0) ? -a : a;
  endfunction

  function automatic void model(input logic [199:0] w, input int te, input int ti,
                                input int tg, output int opix, output int ocls);
    int v[25]; int med[4]; int t[9]; int s[4];
    int c, rf, best, d, base, num, den, r, rw, dr, dc, ch, sw, wt, x;
    for (int p = 0; p < 25; p++) v[p] = int'(w[p*8 +: 8]);
    for (int q = 0; q < 4; q++) begin
      for (int k = 0; k < 9; k++) t[k] = v[((q/2)*2 + k/3)*5 + (q%2)*2 + k%3];
      for (int i = 1; i < 9; i++) begin
        x = t[i];
        for (int j = i; j > 0; j--) if (t[j-1] > x) begin t[j] = t[j-1]; t[j-1] = x; end
      end
      med[q] = t[4];
    end
    for (int q = 0; q < 4; q++) s[q] = med[q];
    for (int i = 1; i < 4; i++) begin
      x = s[i];
      for (int j = i; j > 0; j--) if (s[j-1] > x) begin s[j] = s[j-1]; s[j-1] = x; end
    end
    c = v[12];
    if (s[3] - s[0] > te) begin
      best = 1000; rf = 0;
      for (int q = 0; q < 4; q++) if (iabs(med[q] - c) < best) begin best = iabs(med[q] - c); rf = med[q]; end
    end else rf = (s[1] + s[2]) / 2;
    d = iabs(c - rf);
    ocls = (d >= ti) ? 2 : (d >= tg) ? 1 : 0;
    if (ocls == 0) begin opix = c; return; end
    base = (ocls == 2) ? rf : c;
    num = 0; den = 0;
    for (int p = 0; p < 25; p++) begin
      r  = iabs(v[p] - base) / 4;
      rw = (r >= 16) ? 0 : 16 - r;
      dr = iabs(p / 5 - 2); dc = iabs(p % 5 - 2);
      ch = (dr > dc) ? dr : dc;
      sw = (ch == 0) ? 4 : (ch == 1) ? 2 : 1;
      wt = sw * rw;
      if (ocls == 2 && p == 12) wt = 0;
      num += wt * v[p]; den += wt;
    end
    opix = (den == 0) ? rf : num / den;
  endfunction

  function automatic logic [199:0] flat(input int val);
    logic [199:0] w;
    for (int p = 0; p < 25; p++) w[p*8 +: 8] = 8'(val);
    return w;
  endfunction

  task automatic send(input logic [199:0] w, input string req);
    item_t it;
    int ep, ec;
    model(w, int'(thr_edge), int'(thr_imp), int'(thr_gauss), ep, ec);
    it.pix = ep; it.cls = ec; it.tag = tagc; it.due = cyc + LAT; it.req = req;
    sb.push_back(it);
    in_valid = 1'b1; in_win = w; in_tag = 16'(tagc);
    tagc++;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic drain();
    repeat (LAT + 4) @(negedge clk);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      total++;
      if (sb.size() == 0) begin
        bad++;
        $display("FAIL R8 unexpected output: got pix=%0d cls=%0d, expected none", out_pix, out_class);
      end else begin
        item_t e;
        e = sb.pop_front();
        if (int'(out_pix) != e.pix || int'(out_class) != e.cls ||
            int'(out_tag) != e.tag || cyc != e.due) begin
          bad++;
          $display("FAIL %s: got pix=%0d cls=%0d tag=%0d cyc=%0d, expected pix=%0d cls=%0d tag=%0d cyc=%0d",
                   e.req, out_pix, out_class, out_tag, cyc, e.pix, e.cls, e.tag, e.due);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: got hung run, expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [199:0] w;
    rst_n = 1'b0; in_valid = 1'b0; in_win = '0; in_tag = '0;
    thr_edge = 8'd40; thr_imp = 8'd60; thr_gauss = 8'd10;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    total++;
    if (out_valid !== 1'b0) begin
      bad++; $display("FAIL R8 reset state: got out_valid=%b, expected 0", out_valid);
    end

    // R5: clean pixel passes through
    w = flat(77); w[12*8 +: 8] = 8'd80; send(w, "R5");
    send(flat(33), "R5");
    // R6: Gaussian-noisy centre
    w = flat(100); w[12*8 +: 8] = 8'd120; send(w, "R6");
    // R7: salt and pepper impulses
    w = flat(100); w[12*8 +: 8] = 8'd255; send(w, "R7");
    w = flat(100); w[12*8 +: 8] = 8'd0;   send(w, "R7");
    // R4: threshold boundaries
    w = flat(100); w[12*8 +: 8] = 8'(100 + 10); send(w, "R4");
    w = flat(100); w[12*8 +: 8] = 8'(100 + 9);  send(w, "R4");
    w = flat(100); w[12*8 +: 8] = 8'(100 + 60); send(w, "R4");
    w = flat(100); w[12*8 +: 8] = 8'(100 + 59); send(w, "R4");
    // R2: vertical edge, centre near the bright side
    for (int r = 0; r < 5; r++)
      for (int c = 0; c < 5; c++) w[(r*5+c)*8 +: 8] = (c < 2) ? 8'd0 : 8'd200;
    w[12*8 +: 8] = 8'd190; send(w, "R2");
    // R3: low spread, mean of middle medians
    for (int p = 0; p < 25; p++) w[p*8 +: 8] = 8'(90 + (p * 7) % 21);
    w[12*8 +: 8] = 8'd150; send(w, "R3");
    drain();

    // R7: zero total weight falls back to the reference (mean mode forced)
    thr_edge = 8'd255;
    for (int r = 0; r < 5; r++)
      for (int c = 0; c < 5; c++) w[(r*5+c)*8 +: 8] = (r < 3) ? 8'd0 : 8'd200;
    w[12*8 +: 8] = 8'd255; send(w, "R7");
    drain();
    thr_edge = 8'd40;

    // R1 / R8: back-to-back random windows, flat-plus-noise and fully random
    for (int n = 0; n < 60; n++) begin
      if (n % 2 == 0) begin
        w = flat(int'($urandom_range(40, 200)));
        for (int p = 0; p < 25; p++)
          if ($urandom_range(0, 3) == 0) w[p*8 +: 8] = 8'($urandom_range(0, 255));
      end else begin
        for (int p = 0; p < 25; p++) w[p*8 +: 8] = 8'($urandom_range(0, 255));
      end
      send(w, "R1");
    end
    // R8: gapped traffic
    for (int n = 0; n < 20; n++) begin
      for (int p = 0; p < 25; p++) w[p*8 +: 8] = 8'($urandom_range(60, 140));
      send(w, "R8");
      repeat (n % 4) @(negedge clk);
    end
    drain();

    // R2 / R3: different thresholds after the pipeline is empty
    thr_edge = 8'd15; thr_imp = 8'd90; thr_gauss = 8'd25;
    for (int n = 0; n < 30; n++) begin
      for (int p = 0; p < 25; p++)
        w[p*8 +: 8] = 8'((p % 5 < 2) ? $urandom_range(0, 60) : $urandom_range(150, 255));
      w[12*8 +: 8] = 8'($urandom_range(0, 255));
      send(w, "R2");
    end
    drain();

    total++;
    if (sb.size() != 0) begin
      bad++; $display("FAIL R8 missing outputs: got %0d pending, expected 0", sb.size());
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule